// File: doc/BRIEF.md
# Low-power DDR power-up initialization sequencer

This block sits on the controller side of a mobile low-power DDR memory and owns the command bus from power-up until the memory can take ordinary traffic. It keeps the clock enable high from reset onwards. It holds the bus in deselect until the clock source reports that it is stable. It then runs the fixed start-up order: a long NOP interval, a precharge of all banks, two auto-refresh commands, a load of the base mode register and a load of the extended mode register. Every command lasts exactly one clock. It is followed by NOP cycles for the delay that belongs to it.

The delays are compile-time parameters. The long interval is given in microseconds and converted to cycles through a clock-frequency parameter in MHz. The two mode-register words are static inputs. The system would normally tie them to configuration values for burst length, read latency, self-refresh coverage and drive strength.

When the last delay has run out, the block raises `initDone`. From then on it keeps NOP on the bus until a synchronous reset starts the whole procedure again. Read/write traffic, periodic refresh and the data path belong to other blocks.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is high, and afterwards for as long as `clkStable` has not been seen high, the bus carries deselect (`memCsN` = 1) and `initDone` is 0.
- R2: After `clkStable` is first sampled high, the bus shows one more deselect cycle and then exactly WAIT_US*CLK_MHZ consecutive NOP cycles. A NOP is `memCsN`,`memRasN`,`memCasN`,`memWeN` = 0,1,1,1.
- R3: Next comes a single-cycle precharge-all (0,0,1,0) with `memAddr[AP_BIT]` = 1 and every other address and bank bit 0. It is followed by exactly T_RP NOP cycles.
- R4: Next come two auto-refresh commands (0,0,0,1), each one cycle long with address and bank 0. Each is followed by exactly T_RFC NOP cycles.
- R5: Next comes a single-cycle mode-register load (0,0,0,0) with `memBa` = 00 and `memAddr` = `modeRegVal`. It is followed by exactly T_MRD NOP cycles.
- R6: Next comes a single-cycle extended mode-register load (0,0,0,0) with `memBa` = 10 and `memAddr` = `extModeRegVal`. It is followed by exactly T_MRD NOP cycles. No register load uses any other bank code.
- R7: `initDone` rises in the cycle right after the final T_MRD NOP gap. It then stays high, and the bus carries NOP for as long as it is high.
- R8: `memCke` is 1 in every cycle, both during and after reset.
- R9: A synchronous reset at any point of the sequence returns the bus to deselect and clears `initDone`. The block then waits for `clkStable` and replays the whole sequence from the long interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the memory clock |
| rst | input | 1 | Synchronous reset, active high |
| clkStable | input | 1 | High once the memory clock is stable |
| modeRegVal | input | ADDR_W | Word loaded into the base mode register |
| extModeRegVal | input | ADDR_W | Word loaded into the extended mode register |
| memCke | output | 1 | Clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | BA_W | Bank address |
| memAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Sequence complete, memory ready |

## Verification
The full sequence is run twice, each time with a different pair of mode-register words. A swapped, stuck or cross-wired address field therefore shows up as a wrong value on one of the two loads. The first run starts from a clean reset. The second starts after a reset in the middle of the refresh phase, with `clkStable` held low for a while, which separates a true restart from a resume and confirms that the block waits for the clock again. Every gap is counted cycle by cycle, so a delay one cycle short or one cycle long is caught at the exact phase where it occurs. After completion, the ready flag and the NOP bus are watched over a long window to catch a flag that drops or a stray command.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  // What the bus carries in the next cycle
  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_LOAD_BASE,
    CMD_LOAD_EXT
  } busCmd_e;

  // Which delay the gap counter is loaded with
  typedef enum logic [1:0] {
    GAP_POWER,
    GAP_RP,
    GAP_RFC,
    GAP_MRD
  } gapSel_e;

  // Strobes from the control FSM to the bus datapath
  typedef struct packed {
    busCmd_e cmd;
    logic    gapLoad;
    gapSel_e gapSel;
    logic    readyOn;
  } seqStrobe_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpddr_init_ctrl.sv
module lpddr_init_ctrl
  import lpddr_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clkStable,
  input  logic       gapLast,
  output seqStrobe_t strobe
);

  typedef enum logic [3:0] {
    ST_WAIT_CLK,
    ST_POWER,
    ST_PRE,
    ST_RP,
    ST_REF1,
    ST_RFC1,
    ST_REF2,
    ST_RFC2,
    ST_LOAD_BASE,
    ST_MRD1,
    ST_LOAD_EXT,
    ST_MRD2,
    ST_READY
  } seqState_e;

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT_CLK;
    else     state <= nextState;
  end

  always_comb begin
    nextState      = state;
    strobe.cmd     = CMD_NOP;
    strobe.gapLoad = 1'b0;
    strobe.gapSel  = GAP_POWER;
    strobe.readyOn = 1'b0;
    unique case (state)
      ST_WAIT_CLK: begin
        strobe.cmd = CMD_DESEL;
        if (clkStable) begin
          strobe.gapLoad = 1'b1;
          strobe.gapSel  = GAP_POWER;
          nextState      = ST_POWER;
        end
      end
      ST_POWER: if (gapLast) nextState = ST_PRE;
      ST_PRE: begin
        strobe.cmd     = CMD_PRE_ALL;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_RP;
        nextState      = ST_RP;
      end
      ST_RP: if (gapLast) nextState = ST_REF1;
      ST_REF1: begin
        strobe.cmd     = CMD_REFRESH;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_RFC;
        nextState      = ST_RFC1;
      end
      ST_RFC1: if (gapLast) nextState = ST_REF2;
      ST_REF2: begin
        strobe.cmd     = CMD_REFRESH;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_RFC;
        nextState      = ST_RFC2;
      end
      ST_RFC2: if (gapLast) nextState = ST_LOAD_BASE;
      ST_LOAD_BASE: begin
        strobe.cmd     = CMD_LOAD_BASE;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_MRD;
        nextState      = ST_MRD1;
      end
      ST_MRD1: if (gapLast) nextState = ST_LOAD_EXT;
      ST_LOAD_EXT: begin
        strobe.cmd     = CMD_LOAD_EXT;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_MRD;
        nextState      = ST_MRD2;
      end
      ST_MRD2: if (gapLast) nextState = ST_READY;
      ST_READY: strobe.readyOn = 1'b1;
      default: nextState = ST_WAIT_CLK;
    endcase
  end

endmodule

// File: rtl/lpddr_init_bus.sv
module lpddr_init_bus
  import lpddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned AP_BIT   = 10,
  parameter int unsigned WAIT_CYC = 40000,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RFC    = 15,
  parameter int unsigned T_MRD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeRegVal,
  input  logic [ADDR_W-1:0] extModeRegVal,
  output logic              gapLast,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  localparam int unsigned GAP_MAX = maxOf(maxOf(WAIT_CYC, T_RP), maxOf(T_RFC, T_MRD));
  localparam int unsigned CNT_W   = $clog2(GAP_MAX + 1);
  localparam logic [BA_W-1:0] BA_BASE = '0;
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(2);

  // Gap counter: loaded with the delay, counts down to 1
  logic [CNT_W-1:0] gapCnt, gapLoadVal;

  always_comb begin
    unique case (strobe.gapSel)
      GAP_POWER: gapLoadVal = CNT_W'(WAIT_CYC);
      GAP_RP:    gapLoadVal = CNT_W'(T_RP);
      GAP_RFC:   gapLoadVal = CNT_W'(T_RFC);
      GAP_MRD:   gapLoadVal = CNT_W'(T_MRD);
      default:   gapLoadVal = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  gapCnt <= '0;
    else if (strobe.gapLoad)  gapCnt <= gapLoadVal;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  assign gapLast = (gapCnt == CNT_W'(1));

  // Command decode: {cs, ras, cas, we} plus bank and address
  logic [3:0]        pinNext;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    pinNext  = 4'b0111;
    baNext   = '0;
    addrNext = '0;
    unique case (strobe.cmd)
      CMD_DESEL:   pinNext = 4'b1111;
      CMD_NOP:     pinNext = 4'b0111;
      CMD_PRE_ALL: begin
        pinNext          = 4'b0010;
        addrNext[AP_BIT] = 1'b1;
      end
      CMD_REFRESH: pinNext = 4'b0001;
      CMD_LOAD_BASE: begin
        pinNext  = 4'b0000;
        baNext   = BA_BASE;
        addrNext = modeRegVal;
      end
      CMD_LOAD_EXT: begin
        pinNext  = 4'b0000;
        baNext   = BA_EXT;
        addrNext = extModeRegVal;
      end
      default: pinNext = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {memCsN, memRasN, memCasN, memWeN} <= 4'b1111;
      memBa    <= '0;
      memAddr  <= '0;
      initDone <= 1'b0;
    end else begin
      {memCsN, memRasN, memCasN, memWeN} <= pinNext;
      memBa    <= baNext;
      memAddr  <= addrNext;
      initDone <= strobe.readyOn;
    end
  end

  // Clock enable is held high from reset onwards
  always_ff @(posedge clk) memCke <= 1'b1;

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WAIT_US = 200,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned T_RFC   = 15,
  parameter int unsigned T_MRD   = 2,
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned AP_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkStable,
  input  logic [ADDR_W-1:0] modeRegVal,
  input  logic [ADDR_W-1:0] extModeRegVal,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  localparam int unsigned WAIT_CYC = WAIT_US * CLK_MHZ;

  seqStrobe_t strobe;
  logic       gapLast;

  lpddr_init_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clkStable (clkStable),
    .gapLast   (gapLast),
    .strobe    (strobe)
  );

  lpddr_init_bus #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .AP_BIT   (AP_BIT),
    .WAIT_CYC (WAIT_CYC),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .T_MRD    (T_MRD)
  ) u_bus (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .modeRegVal    (modeRegVal),
    .extModeRegVal (extModeRegVal),
    .gapLast       (gapLast),
    .memCke        (memCke),
    .memCsN        (memCsN),
    .memRasN       (memRasN),
    .memCasN       (memCasN),
    .memWeN        (memWeN),
    .memBa         (memBa),
    .memAddr       (memAddr),
    .initDone      (initDone)
  );

endmodule

// File: rtl/lpddr_init_chk.sv
module lpddr_init_chk #(
  parameter int unsigned BA_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            memCke,
  input logic            memCsN,
  input logic            memRasN,
  input logic            memCasN,
  input logic            memWeN,
  input logic [BA_W-1:0] memBa,
  input logic            initDone
);

  localparam logic [BA_W-1:0] BA_EXT = BA_W'(2);

  logic busNop, busCmd, busLoad;
  assign busNop  = !memCsN && memRasN && memCasN && memWeN;
  assign busCmd  = !memCsN && !(memRasN && memCasN && memWeN);
  assign busLoad = !memCsN && !memRasN && !memCasN && !memWeN;

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (rst) memCke); // R8
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst) busCmd |=> busNop); // R3
  AST_LOAD_BANK: assert property (@(posedge clk) disable iff (rst)
    busLoad |-> (memBa == '0 || memBa == BA_EXT)); // R6
  AST_READY_NOP: assert property (@(posedge clk) disable iff (rst) initDone |-> busNop); // R7
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst) initDone |=> initDone); // R7
  AST_DESEL_NOT_READY: assert property (@(posedge clk) disable iff (rst) memCsN |-> !initDone); // R1

endmodule

bind lpddr_init_seq lpddr_init_chk #(.BA_W(BA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .memCke   (memCke),
  .memCsN   (memCsN),
  .memRasN  (memRasN),
  .memCasN  (memCasN),
  .memWeN   (memWeN),
  .memBa    (memBa),
  .initDone (initDone)
);

// File: tb/test_lpddr_init_seq.sv
module test_lpddr_init_seq;

  localparam int CLK_MHZ = 250;
  localparam int WAIT_US = 1;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 7;
  localparam int T_MRD   = 2;
  localparam int ADDR_W  = 14;
  localparam int BA_W    = 2;
  localparam int AP_BIT  = 10;
  localparam int EXP_WAIT = 250;   // 1 us at 250 MHz

  // bus codes used by the bench
  localparam int C_DESEL = 0, C_NOP = 1, C_PRE = 2, C_REF = 3, C_LOAD = 4, C_OTHER = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              clkStable;
  logic [ADDR_W-1:0] modeRegVal, extModeRegVal;
  logic              memCke, memCsN, memRasN, memCasN, memWeN, initDone;
  logic [BA_W-1:0]   memBa;
  logic [ADDR_W-1:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpddr_init_seq #(
    .CLK_MHZ (CLK_MHZ), .WAIT_US (WAIT_US), .T_RP (T_RP), .T_RFC (T_RFC),
    .T_MRD (T_MRD), .ADDR_W (ADDR_W), .BA_W (BA_W), .AP_BIT (AP_BIT)
  ) i_lpddr_init_seq (
    .clk (clk), .rst (rst), .clkStable (clkStable),
    .modeRegVal (modeRegVal), .extModeRegVal (extModeRegVal),
    .memCke (memCke), .memCsN (memCsN), .memRasN (memRasN), .memCasN (memCasN),
    .memWeN (memWeN), .memBa (memBa), .memAddr (memAddr), .initDone (initDone)
  );

  function automatic int busCode();
    case ({memCsN, memRasN, memCasN, memWeN})
      4'b0111: return C_NOP;
      4'b0010: return C_PRE;
      4'b0001: return C_REF;
      4'b0000: return C_LOAD;
      default: return memCsN ? C_DESEL : C_OTHER;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // n cycles of one quiet code, initDone low, cke high; one check per kind
  task automatic expectQuiet(input int n, input int code, input string req);
    int badCode = -1;
    int badCnt  = 0;
    bit readyBad = 0;
    bit ckeBad   = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busCode() != code) begin
        if (badCode < 0) badCode = busCode();
        badCnt++;
      end
      if (initDone !== 1'b0) readyBad = 1;
      if (memCke !== 1'b1)   ckeBad = 1;
    end
    check(badCnt == 0, req, "quiet bus code", (badCnt == 0) ? code : badCode, code);
    check(!readyBad, req, "initDone low during gap", readyBad, 0);
    check(!ckeBad, "R8", "cke high", !ckeBad, 1);
  endtask

  task automatic expectCmd(input int code, input logic [BA_W-1:0] expBa,
                           input logic [ADDR_W-1:0] expAddr, input string req);
    @(negedge clk);
    check(busCode() == code, req, "command code", busCode(), code);
    check(memBa == expBa, req, "bank", memBa, expBa);
    check(memAddr == expAddr, req, "address", memAddr, expAddr);
    check(initDone === 1'b0, req, "initDone low at command", initDone, 0);
  endtask

  // clkStable must be sampled high at the next edge
  task automatic runFullSeq(input logic [ADDR_W-1:0] mr, input logic [ADDR_W-1:0] emr);
    logic [ADDR_W-1:0] apAddr = '0;
    apAddr[AP_BIT] = 1'b1;
    expectQuiet(1, C_DESEL, "R2");
    expectQuiet(EXP_WAIT, C_NOP, "R2");
    expectCmd(C_PRE, '0, apAddr, "R3");
    expectQuiet(T_RP, C_NOP, "R3");
    expectCmd(C_REF, '0, '0, "R4");
    expectQuiet(T_RFC, C_NOP, "R4");
    expectCmd(C_REF, '0, '0, "R4");
    expectQuiet(T_RFC, C_NOP, "R4");
    expectCmd(C_LOAD, 2'b00, mr, "R5");
    expectQuiet(T_MRD, C_NOP, "R5");
    expectCmd(C_LOAD, 2'b10, emr, "R6");
    expectQuiet(T_MRD, C_NOP, "R6");
    @(negedge clk);
    check(initDone === 1'b1, "R7", "initDone after last gap", initDone, 1);
    check(busCode() == C_NOP, "R7", "bus NOP when ready", busCode(), C_NOP);
  endtask

  task automatic testReset();
    rst = 1'b1; clkStable = 1'b0;
    modeRegVal = 14'h0032; extModeRegVal = 14'h0020;
    repeat (4) @(negedge clk);
    check(memCsN === 1'b1, "R1", "deselect in reset", memCsN, 1);
    check(initDone === 1'b0, "R1", "initDone low in reset", initDone, 0);
    check(memCke === 1'b1, "R8", "cke high in reset", memCke, 1);
    rst = 1'b0;
    expectQuiet(20, C_DESEL, "R1");
  endtask

  task automatic testFullSequence();
    clkStable = 1'b1;
    runFullSeq(14'h0032, 14'h0020);
  endtask

  task automatic testReadyHold();
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (initDone !== 1'b1 || busCode() != C_NOP || memCke !== 1'b1) bad++;
    end
    check(bad == 0, "R7", "ready held with NOP bus", bad, 0);
  endtask

  task automatic testMidReset();
    rst = 1'b1; clkStable = 1'b0;
    @(negedge clk);
    check(memCsN === 1'b1, "R9", "deselect after reset", memCsN, 1);
    check(initDone === 1'b0, "R9", "initDone cleared", initDone, 0);
    rst = 1'b0;
    expectQuiet(15, C_DESEL, "R9");
    clkStable = 1'b1;
    repeat (EXP_WAIT + T_RP + T_RFC + 4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(memCsN === 1'b1, "R9", "deselect after mid-refresh reset", memCsN, 1);
    check(initDone === 1'b0, "R9", "initDone low after mid reset", initDone, 0);
    modeRegVal = 14'h2A15; extModeRegVal = 14'h15EA;
    rst = 1'b0;
    runFullSeq(14'h2A15, 14'h15EA);  // R9 restart from the long interval
  endtask

  initial begin
    testReset();
    testFullSequence();
    testReadyHold();
    testMidReset();
    testReadyHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule